// File: doc/BRIEF.md
# Multi-channel byte rotor cipher

This block encrypts or decrypts a stream of bytes organised in packets. Each packet opens with a two-byte header. The first header byte picks one of four channels, and each channel carries its own fixed rotor keys and starting rotor positions. The second header byte gives the number of payload bytes that follow. A down-counter then passes exactly that many payload bytes through a pipelined cipher engine. Once the count runs out, the block again treats the next byte as a header.

The engine adds three rotors in turn to the byte, modulo 256. Each rotor contributes its key plus its current position. The byte then goes through a reflector that XORs it with a constant. After that it passes back through mirrored stages that subtract the same three rotors in reverse order. The rotor positions move like an odometer: one step per payload byte, with carries into the next rotor. In encryption the result is finally remapped nibble by nibble. In decryption the inverse nibble maps are applied on entry instead. Because the rotor section is its own inverse, a packet decrypts correctly when it is sent on the same channel with the mode input set.

Top module: `rotor_cipher_top`

## Requirements
- R1: While reset is held, and until the first payload byte has passed through the pipeline, out_valid stays low. After reset the first accepted byte is read as a channel header.
- R2: Header byte one selects the channel from its bits [1:0], and its bits [7:2] are ignored. Header byte two is the payload length, from 0 to 255.
- R3: Exactly length payload bytes are processed, and then the next accepted byte is a new header. A length of 0 yields no output, and the byte after it is a header.
- R4: Each accepted payload byte produces exactly one output. out_valid rises on the 8th rising clock edge counting the edge that captured the byte, and byte order is kept. Header bytes and idle cycles produce no output.
- R5: The rotor section maps x to ((x + S) XOR 0x5A) − S modulo 256, where S = sum over rotors r of (key[ch][r] + pos[r]). Rotor 0 is added first and subtracted last.
- R6: Rotor positions step after each payload byte. pos[0] increments; pos[1] increments when pos[0] wraps from 0xFF; pos[2] increments when pos[1] also wraps from 0xFF.
- R7: When a channel's header byte arrives, that channel's positions reload its initial values. The first payload byte uses the initial positions, and the keys used are those of the channel in the header.
- R8: In encrypt mode (decrypt = 0) the rotor output is remapped last. Its high nibble h becomes (5h + 3) mod 16 and its low nibble l becomes (11l + 7) mod 16.
- R9: In decrypt mode (decrypt = 1) the inverse nibble maps are applied to the input before the rotors, and no remap follows. Ciphertext sent in this mode on the same channel returns the plaintext.
- R10: Cycles with in_valid low change neither the header parser, the payload count nor the rotor positions.
- R11: The mode is sampled with each payload byte, so encrypt and decrypt bytes may be mixed inside one packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_byte carries a header or payload byte this cycle |
| in_byte | input | 8 | Incoming header or payload byte |
| decrypt | input | 1 | 1 selects decryption for the payload byte offered this cycle |
| out_valid | output | 1 | out_byte carries a processed payload byte |
| out_byte | output | 8 | Encrypted or decrypted byte |

## Verification
A payload byte captured on a rising edge appears on the outputs after the eighth rising edge, counting the capture edge. Header bytes and idle cycles must never produce an output. For each byte it drives, the bench computes the expected cipher value with its own odometer and nibble arithmetic. It files that value in a slot indexed by the current cycle count plus eight. On every falling edge it compares the outputs against the slot for that cycle. An empty slot demands out_valid low, which catches outputs that appear early, late or for no reason.

// File: rtl/rotor_cipher_pkg.sv
// Shared counts, types and nibble substitution maps for the rotor cipher.
// Assumes four channels and three rotors of byte width.
package rotor_cipher_pkg;

    localparam int NCH  = 4;
    localparam int NROT = 3;
    localparam int CH_W = $clog2(NCH);

    typedef logic [7:0] byte_t;
    typedef logic [NROT-1:0][7:0] rotset_t;
    typedef logic [NCH-1:0][NROT-1:0][7:0] chanset_t;

    typedef enum logic [1:0] {
        ST_CHAN = 2'd0,
        ST_LEN  = 2'd1,
        ST_BODY = 2'd2
    } hdr_state_e;

    typedef struct packed {
        logic            v;
        logic            dec;
        logic [CH_W-1:0] ch;
        rotset_t         pos;
        byte_t           d;
    } stage_t;

    // Forward nibble maps: high 5h+3, low 11l+7 (mod 16).
    function automatic byte_t sub_fwd(input byte_t b);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = b[7:4] * 4'd5 + 4'd3;
        lo = b[3:0] * 4'd11 + 4'd7;
        return {hi, lo};
    endfunction

    // Inverse nibble maps: high 13m+9, low 3m+11 (mod 16).
    function automatic byte_t sub_inv(input byte_t b);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = b[7:4] * 4'd13 + 4'd9;
        lo = b[3:0] * 4'd3 + 4'd11;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/rc_hdr_ctrl.sv
// Packet parser: reads a channel byte and a length byte, then counts the
// payload bytes down to zero. Assumes one byte per in_valid cycle.
module rc_hdr_ctrl
    import rotor_cipher_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  byte_t           in_byte,
    output logic            fire,
    output logic            hdr_load,
    output logic [CH_W-1:0] sel_chan,
    output hdr_state_e      state,
    output byte_t           remaining
);

    logic [CH_W-1:0] chan_q;

    // Header parsing and the payload down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CHAN;
            chan_q    <= '0;
            remaining <= '0;
        end else if (in_valid) begin
            case (state)
                ST_CHAN: begin
                    chan_q <= in_byte[CH_W-1:0];
                    state  <= ST_LEN;
                end
                ST_LEN: begin
                    remaining <= in_byte;
                    state     <= (in_byte == 8'd0) ? ST_CHAN : ST_BODY;
                end
                ST_BODY: begin
                    remaining <= remaining - 8'd1;
                    if (remaining == 8'd1) state <= ST_CHAN;
                end
                default: state <= ST_CHAN;
            endcase
        end
    end

    // Strobes and the channel that the rotor bank addresses.
    always_comb begin
        fire     = in_valid && (state == ST_BODY);
        hdr_load = in_valid && (state == ST_CHAN);
        sel_chan = (state == ST_CHAN) ? in_byte[CH_W-1:0] : chan_q;
    end

endmodule

// File: rtl/rc_odometer.sv
// Rotor positions for one channel. They step like an odometer and reload
// the initial values on load. Assumes load and step are never set together.
module rc_odometer
    import rotor_cipher_pkg::*;
#(
    parameter rotset_t INIT = '0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  logic    step,
    output rotset_t pos
);

    rotset_t pos_nxt;
    logic    carry;

    // Ripple the carry from rotor 0 upward.
    always_comb begin
        pos_nxt = pos;
        carry   = 1'b1;
        for (int i = 0; i < NROT; i++) begin
            if (carry) pos_nxt[i] = pos[i] + 8'd1;
            carry = carry && (pos[i] == 8'hFF);
        end
    end

    // Position register with reload and step.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= INIT;
        else if (load) pos <= INIT;
        else if (step) pos <= pos_nxt;
    end

endmodule

// File: rtl/rc_rotor_bank.sv
// One odometer per channel; the one addressed by chan loads, steps, and is
// shown on act_pos.
module rc_rotor_bank
    import rotor_cipher_pkg::*;
#(
    parameter chanset_t CH_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [CH_W-1:0] chan,
    output rotset_t         act_pos
);

    rotset_t pos_all [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rc_odometer #(
            .INIT(CH_INIT[c])
        ) u_odo (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load && (chan == CH_W'(c))),
            .step (step && (chan == CH_W'(c))),
            .pos  (pos_all[c])
        );
    end

    assign act_pos = pos_all[chan];

endmodule

// File: rtl/rc_rotor_pipe.sv
// Pipelined cipher datapath: an entry stage (inverse nibble map when
// decrypting), one stage per forward rotor (the reflector sits in the last
// one), one mirrored stage per return rotor, and an output stage (forward
// nibble map when encrypting). Each stage carries the rotor positions and
// channel of its own byte, so the return stages undo exactly what the
// forward stages added.
module rc_rotor_pipe
    import rotor_cipher_pkg::*;
#(
    parameter chanset_t CH_KEY  = '0,
    parameter byte_t    REFLECT = 8'h5A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            decrypt,
    input  byte_t           in_byte,
    input  logic [CH_W-1:0] chan,
    input  rotset_t         pos,
    output logic            out_valid,
    output byte_t           out_byte
);

    localparam int NSTG = 2 * NROT + 1;

    stage_t stg_q [NSTG];
    stage_t stg_d [NSTG];

    // Next value of every stage: entry, forward rotors, return rotors.
    always_comb begin
        stg_d[0].v   = fire;
        stg_d[0].dec = decrypt;
        stg_d[0].ch  = chan;
        stg_d[0].pos = pos;
        stg_d[0].d   = decrypt ? sub_inv(in_byte) : in_byte;
        for (int i = 0; i < NROT; i++) begin
            stg_d[i+1]   = stg_q[i];
            stg_d[i+1].d = stg_q[i].d + CH_KEY[stg_q[i].ch][i] + stg_q[i].pos[i];
        end
        stg_d[NROT].d = stg_d[NROT].d ^ REFLECT;
        for (int j = 0; j < NROT; j++) begin
            stg_d[NROT+1+j]   = stg_q[NROT+j];
            stg_d[NROT+1+j].d = stg_q[NROT+j].d
                              - CH_KEY[stg_q[NROT+j].ch][NROT-1-j]
                              - stg_q[NROT+j].pos[NROT-1-j];
        end
    end

    // Stage registers and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NSTG; k++) stg_q[k] <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            for (int k = 0; k < NSTG; k++) stg_q[k] <= stg_d[k];
            out_valid <= stg_q[NSTG-1].v;
            out_byte  <= stg_q[NSTG-1].dec ? stg_q[NSTG-1].d
                                           : sub_fwd(stg_q[NSTG-1].d);
        end
    end

endmodule

// File: rtl/rotor_cipher_top.sv
// Multi-channel rotor cipher top. Wires the header parser, the per-channel
// rotor bank and the cipher pipeline together. The keys and the initial
// positions are fixed per channel by parameters.
module rotor_cipher_top
    import rotor_cipher_pkg::*;
#(
    parameter chanset_t CH_KEY  = {{8'd11, 8'd22, 8'd33}, {8'd44, 8'd55, 8'd66},
                                   {8'd77, 8'd88, 8'd99}, {8'd3,  8'd5,  8'd7}},
    parameter chanset_t CH_INIT = '0,
    parameter byte_t    REFLECT = 8'h5A
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  logic  decrypt,
    output logic  out_valid,
    output byte_t out_byte
);

    localparam int LATENCY = 2 * NROT + 2;

    logic            fire;
    logic            hdr_load;
    logic [CH_W-1:0] sel_chan;
    hdr_state_e      hdr_state;
    byte_t           remaining;
    rotset_t         act_pos;

    rc_hdr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .fire     (fire),
        .hdr_load (hdr_load),
        .sel_chan (sel_chan),
        .state    (hdr_state),
        .remaining(remaining)
    );

    rc_rotor_bank #(
        .CH_INIT(CH_INIT)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (hdr_load),
        .step   (fire),
        .chan   (sel_chan),
        .act_pos(act_pos)
    );

    rc_rotor_pipe #(
        .CH_KEY (CH_KEY),
        .REFLECT(REFLECT)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .decrypt  (decrypt),
        .in_byte  (in_byte),
        .chan     (sel_chan),
        .pos      (act_pos),
        .out_valid(out_valid),
        .out_byte (out_byte)
    );

endmodule

// File: rtl/rc_checker.sv
// Temporal properties of the rotor cipher, attached to the top by bind.
module rc_checker
    import rotor_cipher_pkg::*;
#(
    parameter chanset_t CH_INIT = '0,
    parameter int       LAT     = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input byte_t           in_byte,
    input logic            fire,
    input logic            hdr_load,
    input logic [CH_W-1:0] sel_chan,
    input hdr_state_e      hdr_state,
    input byte_t           remaining,
    input rotset_t         act_pos,
    input logic            out_valid
);

    logic [LAT-1:0] fire_hist;

    // History of payload accepts, used to check the output latency.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_hist <= '0;
        else        fire_hist <= {fire_hist[LAT-2:0], fire};
    end

    // R4: exactly one output per payload byte, at the fixed latency.
    p_out_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == fire_hist[LAT-1]);

    // R2: the second header byte becomes the payload count.
    p_len_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_state == ST_LEN && in_valid) |=> remaining == $past(in_byte));

    // R3: each payload byte lowers the count by one.
    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> remaining == $past(remaining) - 8'd1);

    // R7: a channel header reloads that channel's initial positions.
    p_load_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_load |=> act_pos == CH_INIT[sel_chan]);

    // R6: the first rotor steps once per payload byte inside a packet.
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && remaining != 8'd1) |=> act_pos[0] == $past(act_pos[0]) + 8'd1);

    // R10: an idle cycle leaves the count and the positions untouched.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && hdr_state != ST_CHAN) |=> $stable(remaining) && $stable(act_pos));

endmodule

bind rotor_cipher_top rc_checker #(
    .CH_INIT(CH_INIT),
    .LAT    (LATENCY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .fire     (fire),
    .hdr_load (hdr_load),
    .sel_chan (sel_chan),
    .hdr_state(hdr_state),
    .remaining(remaining),
    .act_pos  (act_pos),
    .out_valid(out_valid)
);

// File: tb/rotor_cipher_top_test.sv
// Self-checking bench. Expected bytes come from an arithmetic model of the
// requirements and are compared eight edges after each payload byte.
module rotor_cipher_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 8;
    localparam int SLOTS      = 1024;
    localparam logic [7:0] REFL = 8'h5A;

    // Packing: [channel][rotor], rotor 0 rightmost.
    localparam logic [3:0][2:0][7:0] KEYS = {
        {8'd192, 8'd128, 8'd64},
        {8'd99,  8'd7,   8'd250},
        {8'd33,  8'd160, 8'd5},
        {8'd201, 8'd77,  8'd13}};
    localparam logic [3:0][2:0][7:0] INITS = {
        {8'hFF, 8'hFF, 8'hFF},
        {8'h05, 8'hFF, 8'h80},
        {8'h20, 8'h10, 8'hF0},
        {8'h00, 8'h00, 8'h00}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       decrypt = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit done = 0;

    bit         exp_v   [SLOTS];
    logic [7:0] exp_d   [SLOTS];
    string      exp_tag [SLOTS];
    logic [7:0] plain   [256];
    logic [7:0] cipher  [256];

    rotor_cipher_top #(
        .CH_KEY (KEYS),
        .CH_INIT(INITS),
        .REFLECT(REFL)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .decrypt  (decrypt),
        .out_valid(out_valid),
        .out_byte (out_byte)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Position of rotor r for payload byte k of a packet on channel ch.
    function automatic logic [7:0] off_at(int ch, int k, int r);
        int t0, t1, t2;
        t0 = int'(INITS[ch][0]) + k;
        t1 = int'(INITS[ch][1]) + (t0 >> 8);
        t2 = int'(INITS[ch][2]) + (t1 >> 8);
        if (r == 0) return t0[7:0];
        if (r == 1) return t1[7:0];
        return t2[7:0];
    endfunction

    function automatic logic [7:0] rotors(logic [7:0] x, int ch, int k);
        logic [7:0] y;
        y = x;
        for (int r = 0; r < 3; r++) y = y + KEYS[ch][r] + off_at(ch, k, r);
        y = y ^ REFL;
        for (int r = 2; r >= 0; r--) y = y - KEYS[ch][r] - off_at(ch, k, r);
        return y;
    endfunction

    function automatic logic [7:0] nib_f(logic [7:0] x);
        int h, l;
        h = (5 * int'(x[7:4]) + 3) % 16;
        l = (11 * int'(x[3:0]) + 7) % 16;
        return {h[3:0], l[3:0]};
    endfunction

    // Inverse found by search over the forward map.
    function automatic logic [7:0] nib_i(logic [7:0] x);
        logic [7:0] res;
        res = '0;
        for (int n = 0; n < 256; n++)
            if (nib_f(8'(n)) == x) res = 8'(n);
        return res;
    endfunction

    function automatic logic [7:0] model(logic [7:0] x, int ch, int k, bit dec);
        if (dec) return rotors(nib_i(x), ch, k);
        return nib_f(rotors(x, ch, k));
    endfunction

    task automatic check(bit ok, string tag, logic v, logic [7:0] a,
                         logic ev, logic [7:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: out_valid=%0b out_byte=%02h expected valid=%0b byte=%02h",
                     tag, v, a, ev, e);
        end
    endtask

    // Compares every cycle with the slot filed eight edges earlier.
    always @(negedge clk) begin
        if (mon_on) begin
            automatic int idx = cyc % SLOTS;
            if (exp_v[idx]) begin
                check(out_valid === 1'b1 && out_byte === exp_d[idx], exp_tag[idx],
                      out_valid, out_byte, 1'b1, exp_d[idx]);
                exp_v[idx] = 1'b0;
            end else begin
                check(out_valid === 1'b0, "R4 no output expected", out_valid, out_byte,
                      1'b0, 8'h00);
            end
        end
    end

    task automatic send(logic [7:0] b, bit dec, bit want, logic [7:0] e, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        decrypt  = dec;
        if (want) begin
            automatic int idx = (cyc + LAT) % SLOTS;
            exp_v[idx]   = 1'b1;
            exp_d[idx]   = e;
            exp_tag[idx] = tag;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hA5;
            decrypt  = ~decrypt;
        end
    endtask

    // mode: 0 encrypt, 1 decrypt, 2 alternate per byte. Data from plain[].
    task automatic packet(logic [7:0] hdr, int len, int mode, int gap, string tag);
        int ch;
        ch = int'(hdr[1:0]);
        send(hdr, 1'b0, 1'b0, 8'h00, tag);
        send(8'(len), 1'b1, 1'b0, 8'h00, tag);
        for (int k = 0; k < len; k++) begin
            automatic bit dec = (mode == 1) || (mode == 2 && k[0]);
            automatic logic [7:0] e = model(plain[k], ch, k, dec);
            cipher[k] = e;
            send(plain[k], dec, 1'b1, e, tag);
            if (gap > 0 && (k % 5) == 4) idle(gap);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) exp_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset", out_valid, out_byte, 1'b0, 8'h00);
        rst_n = 1'b1;
        mon_on = 1;

        // R5 R6 R8: full-length encrypt on channel 0.
        for (int k = 0; k < 256; k++) plain[k] = 8'(k * 7 + 3);
        packet(8'h00, 255, 0, 0, "R5/R6/R8 ch0 encrypt");
        idle(3);

        // R9 R7: decrypt the previous ciphertext back to the plaintext.
        for (int k = 0; k < 256; k++) begin
            automatic logic [7:0] p = 8'(k * 7 + 3);
            plain[k] = cipher[k];
            cipher[k] = p;
        end
        packet(8'h00, 255, 1, 0, "R9/R7 ch0 round trip");
        idle(2);

        // R2 R10: upper header bits ignored (0xFD selects channel 1), idle gaps.
        for (int k = 0; k < 256; k++) plain[k] = 8'(255 - k);
        packet(8'hFD, 200, 0, 2, "R2/R10 ch1 gaps");
        idle(1);

        // R6: carry reaches rotor 2 on channel 2.
        for (int k = 0; k < 256; k++) plain[k] = 8'(k);
        packet(8'h02, 255, 0, 0, "R6 ch2 carry");

        // R6: all rotors wrap together on channel 3.
        packet(8'h03, 3, 0, 0, "R6 ch3 wrap");

        // R3: zero-length packet, then a normal one directly behind it.
        packet(8'h00, 0, 0, 0, "R3 empty");
        packet(8'h00, 4, 0, 0, "R3 after empty");

        // R11: mode mixed per byte.
        for (int k = 0; k < 256; k++) plain[k] = 8'(k * 13 + 1);
        packet(8'h02, 6, 2, 1, "R11 mixed mode");

        // R3 R7: back-to-back packets, channel 1 then channel 3.
        packet(8'h01, 2, 0, 0, "R3/R7 back-to-back a");
        packet(8'h03, 5, 0, 0, "R3/R7 back-to-back b");
        idle(LAT + 4);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: out_valid=%0b out_byte=%02h expected valid=1 byte=--",
                     out_valid, out_byte);
            finish_run();
        end
    end

endmodule